// File: doc/BRIEF.md
# Residual time stamp generator

This block measures a constant-bit-rate service clock against a network reference clock and reports the result as a short residual count. A counter in the reference domain runs without stopping. On the service side, a divider counts `DIV_N` service clock edges and marks each completed group by flipping a toggle level. That level crosses into the reference domain through a chain of flip-flops. The far end detects each change and turns it into a one-cycle capture pulse. The pulse copies the low `STAMP_W` bits of the counter into an output register and raises a strobe for one reference cycle.

Because the divided service period is usually not a whole number of reference cycles, the gap between consecutive stamps moves between the two integers on either side of that ratio. Downstream logic can rebuild the service frequency from this sequence. The counter wraps at `2**STAMP_W`, so the stamp is the reference cycle count modulo that power of two.

Top module: `rts_gen`

## Requirements
- R1: The reference counter advances by one on every reference clock edge out of reset and wraps from `2**STAMP_W-1` to 0. It is never cleared or held by a capture.
- R2: Exactly one capture happens for every `DIV_N` rising edges of the service clock. The first capture follows the `DIV_N`-th service edge after reset.
- R3: A captured stamp equals the counter value from just before the capturing reference edge. Counted modulo `2**STAMP_W`, it lies `SYNC_STAGES` or `SYNC_STAGES+1` reference cycles past the counter value seen at the service edge that completed the group.
- R4: `stamp_valid_o` is high for exactly one reference cycle per captured stamp, and is low in the cycle before each strobe.
- R5: Between strobes `stamp_o` holds its value. While the service clock is stopped, no strobe occurs.
- R6: Two consecutive stamps taken at a steady clock ratio differ, modulo `2**STAMP_W`, by either the floor or the ceiling of `DIV_N * T_svc / T_ref`.
- R7: While `rst_ni` is low, `stamp_o` is 0 and `stamp_valid_o` is 0, whatever the clocks are doing. The counter, divider, toggle and synchronizer are cleared as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Network reference clock |
| svc_clk_i | input | 1 | Service clock, asynchronous to the reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| stamp_o | output | STAMP_W | Latest residual time stamp |
| stamp_valid_o | output | 1 | One-cycle strobe marking a new stamp |

## Verification
The hardest condition to create from the ports is a non-integer clock ratio that makes the stamp gap alternate between two values. A single fixed ratio, or ratios that are multiples of each other, would hide an off-by-one error in the divider or the counter. The stimulus runs the service clock at several half-periods chosen so that the divided period is 3.25, 4.55, 7.85 and 3.85 reference cycles, with a small `DIV_N`. Every gap is checked against the floor/ceiling pair, and every stamp is checked against the bench's own count of reference edges taken at the service event. Stopping the service clock and pulsing reset mid-stream reach the hold and clear conditions.

// File: rtl/rts_pkg.sv
package rts_pkg;
  // width of a counter that must hold 0..n-1, never below 1
  function automatic int unsigned cnt_width(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rts_svc_divider.sv
module rts_svc_divider #(
  parameter int unsigned DIV_N = 3008
) (
  input  logic svc_clk_i,
  input  logic rst_ni,
  output logic tgl_o
);
  localparam int unsigned CW = rts_pkg::cnt_width(DIV_N);

  logic tgl_q;

  generate
    if (DIV_N == 1) begin : g_div1
      always_ff @(posedge svc_clk_i or negedge rst_ni) begin
        if (!rst_ni) tgl_q <= 1'b0;
        else         tgl_q <= ~tgl_q;
      end
    end else begin : g_divn
      logic [CW-1:0] div_q;
      always_ff @(posedge svc_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          div_q <= '0;
          tgl_q <= 1'b0;
        end else if (div_q == CW'(DIV_N - 1)) begin
          div_q <= '0;
          tgl_q <= ~tgl_q;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  endgenerate

  assign tgl_o = tgl_q;
endmodule

// File: rtl/rts_sync.sv
module rts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  localparam int unsigned LEN = (STAGES < 2) ? 2 : STAGES;

  logic [LEN-1:0] chain_q;
  logic           last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[LEN-2:0], async_i};
      last_q  <= chain_q[LEN-1];
    end
  end

  // any level change of the toggle is one event
  assign pulse_o = chain_q[LEN-1] ^ last_q;
endmodule

// File: rtl/rts_ref_counter.sv
module rts_ref_counter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rts_gen.sv
module rts_gen #(
  parameter int unsigned DIV_N       = 3008,
  parameter int unsigned STAMP_W     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               ref_clk_i,
  input  logic               svc_clk_i,
  input  logic               rst_ni,
  output logic [STAMP_W-1:0] stamp_o,
  output logic               stamp_valid_o
);
  logic               tgl;
  logic               cap;
  logic [STAMP_W-1:0] cnt_q;
  logic [STAMP_W-1:0] stamp_q;
  logic               valid_q;

  rts_svc_divider #(.DIV_N(DIV_N)) i_div (
    .svc_clk_i (svc_clk_i),
    .rst_ni    (rst_ni),
    .tgl_o     (tgl)
  );

  rts_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (ref_clk_i),
    .rst_ni  (rst_ni),
    .async_i (tgl),
    .pulse_o (cap)
  );

  rts_ref_counter #(.WIDTH(STAMP_W)) i_cnt (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_q)
  );

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cap;
      if (cap) stamp_q <= cnt_q;
    end
  end

  assign stamp_o       = stamp_q;
  assign stamp_valid_o = valid_q;
endmodule

// File: rtl/rts_gen_chk.sv
module rts_gen_chk #(
  parameter int unsigned STAMP_W = 4
) (
  input logic               ref_clk_i,
  input logic               rst_ni,
  input logic [STAMP_W-1:0] cnt_i,
  input logic [STAMP_W-1:0] stamp_i,
  input logic               valid_i
);
  p_cnt_step_r1: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> cnt_i == $past(cnt_i) + 1'b1);

  p_stamp_is_cnt_r3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (valid_i && $past(rst_ni)) |-> stamp_i == $past(cnt_i));

  p_single_strobe_r4: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_stamp_hold_r5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(stamp_i));

  always @(negedge ref_clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r7: assert (stamp_i == '0 && !valid_i);
    end
  end
endmodule

bind rts_gen rts_gen_chk #(.STAMP_W(STAMP_W)) i_rts_gen_chk (
  .ref_clk_i (ref_clk_i),
  .rst_ni    (rst_ni),
  .cnt_i     (cnt_q),
  .stamp_i   (stamp_o),
  .valid_i   (stamp_valid_o)
);

// File: tb/test_rts_gen.sv
module test_rts_gen;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned DIV_N   = 5;
  localparam int unsigned STAMP_W = 4;
  localparam int unsigned SYNC    = 2;
  localparam int          MASK    = (1 << STAMP_W) - 1;

  typedef struct packed {
    int half_ps;
    int lo;
    int hi;
    int events;
  } row_t;

  // divided period / 20 ns = half_ps * 2 * 5 / 20000
  localparam int NROWS = 4;
  localparam row_t ROWS [NROWS] = '{
    '{6500,  3, 4, 40},
    '{9100,  4, 5, 40},
    '{15700, 7, 8, 30},
    '{7700,  3, 4, 40}
  };

  logic ref_clk = 1'b0;
  logic svc_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic [STAMP_W-1:0] stamp;
  logic stamp_valid;

  int  svc_half_ps = 6500;
  bit  svc_run = 1'b0;
  int  total = 0;
  int  bad = 0;
  int  cur_lo = 0;
  int  cur_hi = 0;

  int  bcnt = 0;
  int  bdiv = 0;
  int  fifo [8];
  int  wr = 0;
  int  rd = 0;
  int  n_events = 0;
  int  n_strobes = 0;
  bit  prev_v = 1'b0;
  bit  prev_ok = 1'b0;
  int  prev_stamp = 0;

  rts_gen #(.DIV_N(DIV_N), .STAMP_W(STAMP_W), .SYNC_STAGES(SYNC)) i_rts_gen (
    .ref_clk_i     (ref_clk),
    .svc_clk_i     (svc_clk),
    .rst_ni        (rst_n),
    .stamp_o       (stamp),
    .stamp_valid_o (stamp_valid)
  );

  always #10 ref_clk = ~ref_clk;

  always begin
    if (svc_run) begin
      #(svc_half_ps * 1ps);
      svc_clk = ~svc_clk;
    end else begin
      #1ns;
    end
  end

  task automatic check(bit ok, string req, int act, int lo, int hi);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reference edge count model
  always @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) bcnt <= 0;
    else        bcnt <= bcnt + 1;
  end

  // divided service event model: record count seen at the completing edge
  always @(posedge svc_clk or negedge rst_n) begin
    if (!rst_n) begin
      bdiv      = 0;
      wr        = 0;
      rd        = 0;
      n_events  = 0;
      n_strobes = 0;
      prev_ok   = 1'b0;
    end else if (bdiv == DIV_N - 1) begin
      bdiv = 0;
      fifo[wr % 8] = bcnt;
      wr++;
      n_events++;
    end else begin
      bdiv++;
    end
  end

  always @(negedge ref_clk) begin
    if (rst_n) begin
      if (stamp_valid) begin
        n_strobes++;
        if (wr == rd) begin
          check(1'b0, "R2 strobe without event", n_strobes, n_events, n_events);
        end else begin
          int d;
          d = (int'(stamp) - fifo[rd % 8]) & MASK;
          rd++;
          check(d == SYNC || d == SYNC + 1, "R1/R3 stamp offset", d, SYNC, SYNC + 1);
        end
        check(!prev_v, "R4 strobe width", int'(prev_v), 0, 0);
        if (prev_ok) begin
          int g;
          g = (int'(stamp) - prev_stamp) & MASK;
          check(g >= cur_lo && g <= cur_hi, "R6 stamp gap", g, cur_lo, cur_hi);
        end
        prev_ok    = 1'b1;
        prev_stamp = int'(stamp);
      end
      prev_v = stamp_valid;
    end else begin
      prev_v = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge ref_clk);
    check(1'b0, "R4 watchdog", 0, 1, 1);
    finish_run();
  end

  initial begin
    // reset state
    svc_run = 1'b1;
    repeat (4) @(negedge ref_clk);
    check(stamp == '0, "R7 reset stamp", int'(stamp), 0, 0);
    check(!stamp_valid, "R7 reset strobe", int'(stamp_valid), 0, 0);
    svc_run = 1'b0;
    @(negedge ref_clk);
    rst_n = 1'b1;
    @(negedge ref_clk);

    // ratio table
    for (int r = 0; r < NROWS; r++) begin
      int start;
      start       = n_events;
      svc_half_ps = ROWS[r].half_ps;
      cur_lo      = ROWS[r].lo;
      cur_hi      = ROWS[r].hi;
      prev_ok     = 1'b0;
      svc_run     = 1'b1;
      wait (n_events >= start + ROWS[r].events);
      svc_run = 1'b0;
      repeat (8) @(negedge ref_clk);
      prev_ok = 1'b0;
      check(n_strobes == n_events, "R2 capture count", n_strobes, n_events, n_events);
    end

    // stopped service clock: nothing moves
    begin
      int s0;
      int c0;
      s0 = int'(stamp);
      c0 = n_strobes;
      repeat (40) @(negedge ref_clk);
      check(int'(stamp) == s0, "R5 stamp held", int'(stamp), s0, s0);
      check(n_strobes == c0, "R5 no strobe", n_strobes, c0, c0);
    end

    // reset in mid stream
    svc_half_ps = 6500;
    cur_lo      = 3;
    cur_hi      = 4;
    svc_run     = 1'b1;
    wait (n_events >= 6);
    @(negedge ref_clk);
    #3 rst_n = 1'b0;
    #1;
    check(stamp == '0, "R7 async clear stamp", int'(stamp), 0, 0);
    check(!stamp_valid, "R7 async clear strobe", int'(stamp_valid), 0, 0);
    repeat (3) @(negedge ref_clk);
    check(stamp == '0 && !stamp_valid, "R7 held in reset", int'(stamp), 0, 0);
    rst_n = 1'b1;
    wait (n_events >= 10);
    svc_run = 1'b0;
    repeat (8) @(negedge ref_clk);
    check(n_strobes == n_events, "R2 count after reset", n_strobes, n_events, n_events);
    check(n_events == 10, "R2 events after reset", n_events, 10, 10);

    finish_run();
  end
endmodule